// File: doc/BRIEF.md
# Three-Phase PWM Interlock Conditioner

This block sits between a motor or converter controller and the gate drive of three half-bridge legs. It takes a high-side and a low-side switching request for each leg and turns them into six registered gate commands. Each request is first brought into the local clock domain. Pulses narrower than a runtime minimum width are then dropped. Requests that would turn on both switches of a leg are blocked. A runtime dead time keeps both switches of a leg off for a while before either one turns on.

Two mode inputs change this behaviour. The overlap input turns off the interlock, so each output follows its own filtered request and both switches of a leg may be on together. The lockstep input makes all three legs take their requests from leg 0. The six outputs then switch on the same clock edge, for legs that are wired in parallel or in series.

Top module: `pwm_interlock_top`

## Requirements
- R1: Each request passes through a two-stage synchroniser and then the width filter. When no dead-time wait applies, a request change appears on its output exactly 3 + max(min_width, 1) clock edges after the first edge that samples the change.
- R2: A request level that lasts fewer than max(min_width, 1) clock cycles never reaches the output. A level that lasts exactly that many cycles passes with the same width.
- R3: Interlock mode is selected by overlap_en = 0. In this mode, when both filtered requests of a leg are high, both outputs of that leg go low and that leg's bit of hazard_flag goes high. Bit i belongs to leg i.
- R4: In interlock mode the two outputs of a leg are never high together. Any rising output edge follows a stretch of exactly dead_time + 1 cycles in which both outputs of that leg are low. This holds when the request swaps from one side to the other.
- R5: A falling output edge is never held back by the dead time. It keeps the latency given in R1 for any dead_time value.
- R6: With overlap_en = 1, each output follows its own filtered request, both outputs of a leg may be high together, and hazard_flag stays 0.
- R7: With lockstep_en = 1, every leg uses the request pair of leg 0 (bit 0 of hi_req and lo_req). All three hi_gate bits are then equal on every cycle, and so are all three lo_gate bits.
- R8: While rst_n is low, hi_gate, lo_gate and hazard_flag are all 0. They clear as soon as reset asserts, without waiting for a clock edge.
- R9: With lockstep_en = 0, each leg's outputs depend only on its own request pair, which is bit i of hi_req and lo_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_req | input | 3 | High-side switching requests, bit i for leg i |
| lo_req | input | 3 | Low-side switching requests, bit i for leg i |
| min_width | input | 8 | Minimum accepted pulse width, in clock cycles |
| dead_time | input | 8 | Dead-time count, in clock cycles |
| overlap_en | input | 1 | 1 turns off the interlock and allows free overlap |
| lockstep_en | input | 1 | 1 drives all legs from the leg 0 request pair |
| hi_gate | output | 3 | Conditioned high-side gate commands |
| lo_gate | output | 3 | Conditioned low-side gate commands |
| hazard_flag | output | 3 | Per-leg flag for blocked simultaneous requests |

## Verification
The bench builds the block with its default parameters: three legs and 8-bit counters. At runtime it sets min_width to 4 and 0, and dead_time to 5, 0 and 200. These values keep the windows short enough to measure edge by edge. With them, the bench can measure the exact filter threshold and the exact one-cycle dead-time floor, and it can confirm that a long dead time does not delay a falling edge. With three legs, the bench can give each leg a different pattern, so it can show that the legs are independent and that lockstep forces them to match.

// File: rtl/pwm_il_pkg.sv
package pwm_il_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned LEGS_DEF    = 3;
  localparam int unsigned CNT_W_DEF   = 8;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_pair_t;
endpackage

// File: rtl/pwm_il_sync.sv
module pwm_il_sync #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import pwm_il_pkg::*;

  logic [W-1:0] stage_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/pwm_il_glitch.sv
module pwm_il_glitch #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] min_width,
  input  logic             raw,
  output logic             clean
);
  logic             level_q, level_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] thresh;
  logic [CNT_W-1:0] cnt_inc;

  assign thresh  = (min_width == '0) ? CNT_W'(1) : min_width;
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    level_d = level_q;
    cnt_d   = cnt_q;
    if (raw == level_q) begin
      cnt_d = '0;
    end else if (cnt_inc >= thresh) begin
      level_d = raw;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign clean = level_q;
endmodule

// File: rtl/pwm_il_leg.sv
module pwm_il_leg #(
  parameter int unsigned CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  pwm_il_pkg::leg_pair_t req,
  input  logic                  overlap_en,
  input  logic [CNT_W-1:0]      dead_time,
  output logic                  gate_hi,
  output logic                  gate_lo,
  output logic                  hazard
);
  logic             hi_q, hi_d, lo_q, lo_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] gap_q, gap_d;
  logic             both_req, gap_ok;

  assign both_req = req.hi & req.lo;
  assign gap_ok   = (gap_q >= dead_time);

  always_comb begin
    if (overlap_en) begin
      hi_d = req.hi;
      lo_d = req.lo;
    end else begin
      hi_d = req.hi & ~req.lo & (hi_q | (~lo_q & gap_ok));
      lo_d = req.lo & ~req.hi & (lo_q | (~hi_q & gap_ok));
    end
    flag_d = both_req & ~overlap_en;
    if (hi_q | lo_q)      gap_d = '0;
    else if (gap_q != '1) gap_d = gap_q + CNT_W'(1);
    else                  gap_d = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      flag_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      flag_q <= flag_d;
      gap_q  <= gap_d;
    end
  end

  assign gate_hi = hi_q;
  assign gate_lo = lo_q;
  assign hazard  = flag_q;
endmodule

// File: rtl/pwm_interlock_top.sv
module pwm_interlock_top #(
  parameter int unsigned LEGS  = pwm_il_pkg::LEGS_DEF,
  parameter int unsigned CNT_W = pwm_il_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEGS-1:0]  hi_req,
  input  logic [LEGS-1:0]  lo_req,
  input  logic [CNT_W-1:0] min_width,
  input  logic [CNT_W-1:0] dead_time,
  input  logic             overlap_en,
  input  logic             lockstep_en,
  output logic [LEGS-1:0]  hi_gate,
  output logic [LEGS-1:0]  lo_gate,
  output logic [LEGS-1:0]  hazard_flag
);
  import pwm_il_pkg::*;

  localparam int unsigned CH = 2 * LEGS;

  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic [CH-1:0] synced;
  logic [CH-1:0] filtered;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pwm_il_sync #(.W(CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({lo_req, hi_req}),
    .q     (synced)
  );

  for (genvar c = 0; c < CH; c++) begin : g_filt
    pwm_il_glitch #(.CNT_W(CNT_W)) u_glitch (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .min_width (min_width),
      .raw       (synced[c]),
      .clean     (filtered[c])
    );
  end

  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    leg_pair_t pair;
    always_comb begin
      if (lockstep_en) begin
        pair.hi = filtered[0];
        pair.lo = filtered[LEGS];
      end else begin
        pair.hi = filtered[l];
        pair.lo = filtered[LEGS + l];
      end
    end

    pwm_il_leg #(.CNT_W(CNT_W)) u_leg (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .req        (pair),
      .overlap_en (overlap_en),
      .dead_time  (dead_time),
      .gate_hi    (hi_gate[l]),
      .gate_lo    (lo_gate[l]),
      .hazard     (hazard_flag[l])
    );
  end
endmodule

// File: rtl/pwm_interlock_chk.sv
module pwm_interlock_chk #(
  parameter int unsigned LEGS = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            overlap_en,
  input logic [LEGS-1:0] hi_gate,
  input logic [LEGS-1:0] lo_gate,
  input logic [LEGS-1:0] hazard_flag
);
  // R4: no leg has both switches on when interlock was in force
  assert_no_shoot_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!overlap_en) |-> ((hi_gate & lo_gate) == '0));

  // R4: an output only rises when the opposite side was off
  assert_rise_after_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!overlap_en) |->
      (((hi_gate & ~$past(hi_gate) & $past(lo_gate)) |
        (lo_gate & ~$past(lo_gate) & $past(hi_gate))) == '0));

  // R3: a flagged leg has both outputs low
  assert_flag_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((hazard_flag & (hi_gate | lo_gate)) == '0));

  // R6: no flag is raised while overlap is allowed
  assert_overlap_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overlap_en) |-> (hazard_flag == '0));

  // R8: outputs stay low during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R8: assert ((hi_gate | lo_gate | hazard_flag) == '0);
    end
  end
endmodule

bind pwm_interlock_top pwm_interlock_chk #(.LEGS(LEGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .overlap_en  (overlap_en),
  .hi_gate     (hi_gate),
  .lo_gate     (lo_gate),
  .hazard_flag (hazard_flag)
);

// File: tb/pwm_interlock_top_tb.sv
module pwm_interlock_top_tb;
  logic       clk;
  logic       rst_n;
  logic [2:0] hi_req, lo_req;
  logic [7:0] min_width, dead_time;
  logic       overlap_en, lockstep_en;
  logic [2:0] hi_gate, lo_gate, hazard_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  pwm_interlock_top u_dut (
    .clk(clk), .rst_n(rst_n), .hi_req(hi_req), .lo_req(lo_req),
    .min_width(min_width), .dead_time(dead_time),
    .overlap_en(overlap_en), .lockstep_en(lockstep_en),
    .hi_gate(hi_gate), .lo_gate(lo_gate), .hazard_flag(hazard_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: hi_req, lo_req, overlap, lockstep, exp hi, exp lo, exp flag
  localparam int NV = 10;
  localparam logic [16:0] VEC [NV] = '{
    {3'b001, 3'b010, 1'b0, 1'b0, 3'b001, 3'b010, 3'b000},
    {3'b010, 3'b001, 1'b0, 1'b0, 3'b010, 3'b001, 3'b000},
    {3'b100, 3'b100, 1'b0, 1'b0, 3'b000, 3'b000, 3'b100},
    {3'b100, 3'b100, 1'b1, 1'b0, 3'b100, 3'b100, 3'b000},
    {3'b011, 3'b100, 1'b0, 1'b0, 3'b011, 3'b100, 3'b000},
    {3'b001, 3'b000, 1'b0, 1'b1, 3'b111, 3'b000, 3'b000},
    {3'b110, 3'b001, 1'b0, 1'b1, 3'b000, 3'b111, 3'b000},
    {3'b001, 3'b001, 1'b0, 1'b1, 3'b000, 3'b000, 3'b111},
    {3'b000, 3'b000, 1'b0, 1'b0, 3'b000, 3'b000, 3'b000},
    {3'b101, 3'b011, 1'b1, 1'b0, 3'b101, 3'b011, 3'b000}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // negedges until the chosen output bit reaches the level, 0 if never
  task automatic wait_level(input bit use_lo, input int bitn, input logic lvl,
                            input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (((use_lo ? lo_gate : hi_gate) >> bitn) & 1'b1) begin
        if (lvl) begin k = i; break; end
      end else if (!lvl) begin k = i; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int k, cnt;
    bit bad;
    rst_n = 1'b0; hi_req = 3'b111; lo_req = 3'b000;
    min_width = 8'd4; dead_time = 8'd5; overlap_en = 1'b0; lockstep_en = 1'b0;
    idle(6);
    // R8: outputs low while in reset, even with requests active
    check("R8 reset outputs", {hi_gate, lo_gate, hazard_flag}, 0);
    hi_req = 3'b000;
    idle(2);
    rst_n = 1'b1;
    idle(10);

    // table walk: R3 R6 R7 R9 steady states
    for (int v = 0; v < NV; v++) begin
      hi_req      = VEC[v][16:14];
      lo_req      = VEC[v][13:11];
      overlap_en  = VEC[v][10];
      lockstep_en = VEC[v][9];
      idle(40);
      check($sformatf("vector %0d (R3 R6 R7 R9)", v),
            {hi_gate, lo_gate, hazard_flag}, VEC[v][8:0]);
    end
    overlap_en = 1'b0; lockstep_en = 1'b0; hi_req = 0; lo_req = 0;
    idle(40);

    // R1: rise latency 3 + 4 = 7
    hi_req[1] = 1'b1;
    wait_level(0, 1, 1'b1, 20, k);
    check("R1 rise latency mw=4", k, 7);
    idle(20);
    // R5: falling edge not delayed by a long dead time
    dead_time = 8'd200;
    hi_req[1] = 1'b0;
    wait_level(0, 1, 1'b0, 20, k);
    check("R5 fall latency dt=200", k, 7);
    dead_time = 8'd5;
    idle(40);

    // R1 with min_width 0 acts as 1: latency 4
    min_width = 8'd0;
    hi_req[2] = 1'b1;
    wait_level(0, 2, 1'b1, 20, k);
    check("R1 rise latency mw=0", k, 4);
    hi_req[2] = 1'b0;
    min_width = 8'd4;
    idle(40);

    // R2: 3-cycle pulse is dropped
    hi_req[0] = 1'b1; idle(3); hi_req[0] = 1'b0;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (hi_gate[0]) cnt++; end
    check("R2 short pulse suppressed", cnt, 0);
    // R2: 4-cycle pulse passes with width 4
    hi_req[0] = 1'b1; idle(4); hi_req[0] = 1'b0;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (hi_gate[0]) cnt++; end
    check("R2 min pulse width kept", cnt, 4);
    idle(20);

    // R4: swap leg1 from high to low side, dead time 5 -> 6 idle cycles
    hi_req[1] = 1'b1; idle(40);
    hi_req[1] = 1'b0; lo_req[1] = 1'b1;
    wait_level(0, 1, 1'b0, 20, k);
    cnt = 0;
    while (!lo_gate[1] && cnt < 50) begin
      if (hi_gate[1]) cnt = 100;
      cnt++;
      @(negedge clk);
    end
    check("R4 dead gap dt=5", cnt, 6);
    idle(20);
    // R4: dead time 0 still leaves one idle cycle
    dead_time = 8'd0;
    lo_req[1] = 1'b0; hi_req[1] = 1'b1;
    wait_level(1, 1, 1'b0, 20, k);
    cnt = 0;
    while (!hi_gate[1] && cnt < 50) begin cnt++; @(negedge clk); end
    check("R4 dead gap dt=0", cnt, 1);
    hi_req[1] = 1'b0; dead_time = 8'd5;
    idle(40);

    // R7: lockstep transitions keep legs matched on every cycle
    lockstep_en = 1'b1; hi_req = 3'b001; lo_req = 3'b000;
    idle(40);
    bad = 0;
    hi_req = 3'b000; lo_req = 3'b001;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!(hi_gate inside {3'b000, 3'b111}) || !(lo_gate inside {3'b000, 3'b111})) bad = 1;
    end
    check("R7 lockstep matched edges", {bad, lo_gate}, {1'b0, 3'b111});
    lockstep_en = 1'b0; lo_req = 3'b000;
    idle(40);

    // R8: asynchronous clear mid-run
    hi_req = 3'b111;
    idle(40);
    check("R8 outputs before reset", hi_gate, 3'b111);
    #1 rst_n = 1'b0;
    #1;
    check("R8 async clear", {hi_gate, lo_gate, hazard_flag}, 0);
    idle(3);
    rst_n = 1'b1;

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule